// File: doc/BRIEF.md
# Fractional UART Baud Generator

This block turns one input clock into the timing strobes that a UART transmitter and receiver share. The clock first passes through a prescaler that divides by 1 or by 4. The prescaled rate is then divided by a rational value: a 16-bit integer part N plus a 4-bit fractional part M, spread over a bit time that holds 16, 8 or 4 sample intervals. The result is a per-sample strobe for receiver oversampling and a per-bit strobe for the transmitter shift.

One bit time lasts P × (N × S + M) input clocks, where P is the prescale ratio and S the number of samples per bit. Inside a bit time, M sample intervals are one prescaled cycle longer than the others. A phase accumulator spreads these long intervals evenly, so the sampling point never drifts by more than one prescaled cycle from its ideal position. A change to any configuration field restarts the generator at the start of a bit time.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst` is high, and after its release until the first sample interval has fully elapsed, both `sample_tick` and `bit_tick` are low.
- R2: `presc_sel` = 0 applies each input clock to the divider. `presc_sel` = 1 applies only every fourth input clock, which makes every interval four times longer.
- R3: The integer divisor is N = {`div_hi`, `div_lo`}. A value of 0 acts as 1. Each sample interval lasts N or N+1 prescaled cycles.
- R4: `samp_sel` selects the samples per bit S: 2'b00 gives 16, 2'b01 gives 8, and both 2'b10 and 2'b11 give 4. Exactly S sample ticks occur per bit tick.
- R5: Each bit time lasts P × (N × S + M') input clocks. Exactly M' of its S sample intervals are the long ones (N+1 cycles).
- R6: The effective fraction M' equals `frac` when `frac` < S, and S−1 otherwise.
- R7: `bit_tick` is high only in the same cycle as the `sample_tick` that closes the S-th interval of a bit time, and it lasts one clock.
- R8: When any configuration input changes, the next clock edge clears both strobes and restarts the bit time. The next `bit_tick` then follows one full bit time after that edge.
- R9: After reset or restart, the first `sample_tick` arrives P × N input clocks after the clearing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| div_lo | input | 8 | Integer divisor, low byte |
| div_hi | input | 8 | Integer divisor, high byte |
| frac | input | 4 | Fractional divisor numerator |
| presc_sel | input | 1 | Prescaler select, 0 = ÷1, 1 = ÷4 |
| samp_sel | input | 2 | Samples-per-bit select |
| sample_tick | output | 1 | One-clock strobe per sample interval |
| bit_tick | output | 1 | One-clock strobe per bit time |

## Verification
Both strobes are registered. The clearing edge (a reset or a configuration change) therefore counts as edge 0. A strobe due after T input clocks is visible just after posedge number T. The bench counts posedges from the clearing edge and samples on the following negedge. It then compares the edge index of the first sample tick against P × N, and the first and second bit ticks against one and two bit times. Gap lengths between consecutive sample ticks are classed as short or long from P and N, so the number of long intervals per bit is compared exactly.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

    localparam int BYTE_W      = 8;
    localparam int DIV_W       = 2 * BYTE_W;
    localparam int FRAC_W      = 4;
    localparam int SEL_W       = 2;
    localparam int SCNT_W      = FRAC_W + 1;
    localparam int PRESC_RATIO = 4;

    typedef enum logic [SEL_W-1:0] {
        SAMP_X16  = 2'b00,
        SAMP_X8   = 2'b01,
        SAMP_X4   = 2'b10,
        SAMP_X4_B = 2'b11
    } samp_e;

    typedef struct packed {
        logic [DIV_W-1:0]  n;
        logic [FRAC_W-1:0] m;
        logic              presc;
        samp_e             samp;
    } cfg_t;

    typedef struct packed {
        logic [DIV_W-1:0]  n_eff;
        logic [FRAC_W-1:0] m_eff;
        logic [SCNT_W-1:0] samps;
    } rate_t;

    function automatic logic [SCNT_W-1:0] samps_of(samp_e s);
        case (s)
            SAMP_X16: samps_of = SCNT_W'(16);
            SAMP_X8:  samps_of = SCNT_W'(8);
            default:  samps_of = SCNT_W'(4);
        endcase
    endfunction

    function automatic rate_t resolve(cfg_t c);
        rate_t             r;
        logic [SCNT_W-1:0] lim;
        r.samps = samps_of(c.samp);
        r.n_eff = (c.n == '0) ? DIV_W'(1) : c.n;
        lim     = r.samps - SCNT_W'(1);
        r.m_eff = ({1'b0, c.m} >= r.samps) ? lim[FRAC_W-1:0] : c.m;
        return r;
    endfunction

endpackage

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
    parameter int RATIO = fbg_pkg::PRESC_RATIO
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic sel,
    output logic en
);
    localparam int PC_W = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(RATIO - 1);

    logic [PC_W-1:0] pc;

    assign en = sel ? (pc == PC_LAST) : 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clr) pc <= '0;
        else            pc <= (pc == PC_LAST) ? '0 : pc + PC_W'(1);
    end

    assert_presc_gap_R2: assert property (@(posedge clk) disable iff (rst || clr)
        (sel && en) |=> !en)
        else $error("prescaled enable repeated on consecutive clocks");

endmodule

// File: rtl/fbg_interval.sv
module fbg_interval
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              en,
    input  logic [DIV_W-1:0]  n_eff,
    input  logic [FRAC_W-1:0] m_eff,
    input  logic [SCNT_W-1:0] samps,
    output logic              done
);
    logic [DIV_W-1:0]  cnt;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;
    logic [FRAC_W:0]   acc_nx;
    logic              stretch;
    logic [DIV_W-1:0]  last_idx;

    // Phase accumulator: an interval is stretched whenever adding M crosses S.
    assign sum      = {1'b0, acc} + {1'b0, m_eff};
    assign stretch  = (sum >= samps);
    assign acc_nx   = stretch ? (sum - samps) : sum;
    assign last_idx = stretch ? n_eff : (n_eff - DIV_W'(1));
    assign done     = en && (cnt == last_idx);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            acc <= '0;
        end else if (en) begin
            if (cnt == last_idx) begin
                cnt <= '0;
                acc <= acc_nx[FRAC_W-1:0];
            end else begin
                cnt <= cnt + DIV_W'(1);
            end
        end
    end

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst || clr)
        cnt <= last_idx)
        else $error("interval counter passed its limit");

    assert_acc_bound_R5: assert property (@(posedge clk) disable iff (rst || clr)
        acc_nx < {1'b0, samps})
        else $error("fraction accumulator out of range");

endmodule

// File: rtl/fbg_bitcount.sv
module fbg_bitcount
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              smp_done,
    input  logic [SCNT_W-1:0] samps,
    output logic              bit_done
);
    logic [SCNT_W-1:0] scount;

    assign bit_done = smp_done && (scount == samps - SCNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr)    scount <= '0;
        else if (smp_done) scount <= bit_done ? '0 : scount + SCNT_W'(1);
    end

    assert_scount_R4: assert property (@(posedge clk) disable iff (rst || clr)
        scount < samps)
        else $error("sample counter beyond samples per bit");

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import fbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [FRAC_W-1:0] frac,
    input  logic              presc_sel,
    input  logic [SEL_W-1:0]  samp_sel,
    output logic              sample_tick,
    output logic              bit_tick
);
    cfg_t  cfg_in;
    cfg_t  cfg_q;
    rate_t rate;
    logic  restart;
    logic  pre_en;
    logic  smp_done;
    logic  bit_done;

    assign cfg_in.n     = {div_hi, div_lo};
    assign cfg_in.m     = frac;
    assign cfg_in.presc = presc_sel;
    assign cfg_in.samp  = samp_e'(samp_sel);
    assign rate         = resolve(cfg_in);
    assign restart      = (cfg_in != cfg_q);

    fbg_prescaler #(.RATIO(PRESC_RATIO)) u_presc (
        .clk (clk),
        .rst (rst),
        .clr (restart),
        .sel (cfg_in.presc),
        .en  (pre_en)
    );

    fbg_interval u_intv (
        .clk   (clk),
        .rst   (rst),
        .clr   (restart),
        .en    (pre_en),
        .n_eff (rate.n_eff),
        .m_eff (rate.m_eff),
        .samps (rate.samps),
        .done  (smp_done)
    );

    fbg_bitcount u_bits (
        .clk      (clk),
        .rst      (rst),
        .clr      (restart),
        .smp_done (smp_done),
        .samps    (rate.samps),
        .bit_done (bit_done)
    );

    always_ff @(posedge clk) begin
        cfg_q <= cfg_in;
        if (rst) begin
            sample_tick <= 1'b0;
            bit_tick    <= 1'b0;
        end else begin
            sample_tick <= !restart && smp_done;
            bit_tick    <= !restart && bit_done;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!sample_tick && !bit_tick))
        else $error("strobe active after reset edge");

    assert_bit_on_sample_R7: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick)
        else $error("bit strobe without sample strobe");

    assert_bit_single_R7: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> !bit_tick)
        else $error("bit strobe wider than one clock");

    assert_restart_clear_R8: assert property (@(posedge clk) disable iff (rst)
        restart |=> (!sample_tick && !bit_tick))
        else $error("strobe survived a configuration change");

endmodule

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb;

    typedef struct packed {
        logic [7:0]  lo;
        logic [7:0]  hi;
        logic [3:0]  fr;
        logic        ps;
        logic [1:0]  sm;
        logic [15:0] per;
        logic [15:0] first;
        logic [7:0]  longs;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'd1, 8'd0, 4'd0,  1'b0, 2'd0, 16'd16,   16'd1,   8'd0},
        '{8'd3, 8'd0, 4'd5,  1'b0, 2'd0, 16'd53,   16'd3,   8'd5},
        '{8'd2, 8'd0, 4'd3,  1'b1, 2'd1, 16'd76,   16'd8,   8'd3},
        '{8'd5, 8'd0, 4'd12, 1'b0, 2'd1, 16'd47,   16'd5,   8'd7},
        '{8'd0, 8'd0, 4'd2,  1'b0, 2'd2, 16'd6,    16'd1,   8'd2},
        '{8'd2, 8'd1, 4'd1,  1'b0, 2'd2, 16'd1033, 16'd258, 8'd1},
        '{8'd1, 8'd0, 4'd15, 1'b0, 2'd0, 16'd31,   16'd1,   8'd15},
        '{8'd2, 8'd0, 4'd1,  1'b1, 2'd3, 16'd36,   16'd8,   8'd1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] div_lo = 8'd1;
    logic [7:0] div_hi = 8'd0;
    logic [3:0] frac = 4'd0;
    logic       presc_sel = 1'b0;
    logic [1:0] samp_sel = 2'd0;
    logic       sample_tick;
    logic       bit_tick;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    frac_baud_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .div_lo      (div_lo),
        .div_hi      (div_hi),
        .frac        (frac),
        .presc_sel   (presc_sel),
        .samp_sel    (samp_sel),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts edges after a clearing edge; returns first sample and first two bit ticks.
    task automatic observe(input int ncyc, input int per, input int p, input int neff,
                           output int first_s, output int b1, output int b2,
                           output int nsamp, output int nlong, output int viol);
        int last;
        first_s = -1; b1 = -1; b2 = -1; nsamp = 0; nlong = 0; viol = 0; last = 0;
        for (int k = 1; k <= ncyc; k++) begin
            @(negedge clk);
            if (bit_tick && !sample_tick) viol++;
            if (sample_tick) begin
                if (first_s < 0) first_s = k;
                if (k <= per) begin
                    nsamp++;
                    if (k - last == p * (neff + 1)) nlong++;
                end
                last = k;
            end
            if (bit_tick) begin
                if (b1 < 0) b1 = k;
                else if (b2 < 0) b2 = k;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int fs, b1, b2, ns, nl, vi, p, neff, s;
        // R1: strobes low during reset
        repeat (3) @(negedge clk);
        chk("R1 sample_tick in reset", int'(sample_tick), 0);
        chk("R1 bit_tick in reset", int'(bit_tick), 0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            div_lo = VECS[i].lo; div_hi = VECS[i].hi; frac = VECS[i].fr;
            presc_sel = VECS[i].ps; samp_sel = VECS[i].sm; rst = 1'b1;
            @(negedge clk);
            rst = 1'b0;
            p    = VECS[i].ps ? 4 : 1;
            neff = ({VECS[i].hi, VECS[i].lo} == 16'd0) ? 1 : int'({VECS[i].hi, VECS[i].lo});
            s    = (VECS[i].sm == 2'd0) ? 16 : (VECS[i].sm == 2'd1) ? 8 : 4;
            observe(2 * int'(VECS[i].per) + 2, int'(VECS[i].per), p, neff, fs, b1, b2, ns, nl, vi);
            chk($sformatf("R3 R9 first sample vec%0d", i), fs, int'(VECS[i].first));
            chk($sformatf("R2 R5 first bit vec%0d", i), b1, int'(VECS[i].per));
            chk($sformatf("R5 second bit vec%0d", i), b2, 2 * int'(VECS[i].per));
            chk($sformatf("R4 samples per bit vec%0d", i), ns, s);
            chk($sformatf("R6 R5 long intervals vec%0d", i), nl, int'(VECS[i].longs));
            chk($sformatf("R7 bit without sample vec%0d", i), vi, 0);
        end

        // R8: configuration change mid-bit restarts the bit time
        @(negedge clk);
        div_lo = 8'd1; div_hi = 8'd0; frac = 4'd0; presc_sel = 1'b0; samp_sel = 2'd0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        repeat (7) @(negedge clk);
        frac = 4'd4;
        @(negedge clk);
        chk("R8 strobes cleared on change", int'(sample_tick | bit_tick), 0);
        observe(44, 20, 1, 1, fs, b1, b2, ns, nl, vi);
        chk("R8 first bit after change", b1, 20);
        chk("R8 long intervals after change", nl, 4);

        // R1: reset in mid-run clears strobes and restarts timing
        @(negedge clk);
        div_lo = 8'd3; frac = 4'd5;
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 strobes cleared by reset", int'(sample_tick | bit_tick), 0);
        rst = 1'b0;
        observe(60, 53, 1, 3, fs, b1, b2, ns, nl, vi);
        chk("R1 first sample after reset", fs, 3);
        chk("R1 first bit after reset", b1, 53);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule